// File: doc/BRIEF.md
# Message-Digest Engine Register Front-End

This block is the bus-facing control and status front-end of a multi-algorithm message-digest engine. Software programs a 64-bit message length, counted in bits, and a control word that picks the digest algorithm and the lane order of incoming data bytes. It then streams 32-bit message words into a separate write-only data port. The round logic is represented by a core stub with a start/data/done handshake. When the core reports done, the digest words are loaded into a result queue that software drains one word per read, last digest word first. Sticky error flags record reads of an empty queue and data writes that arrive when the engine cannot take them. One interrupt line is formed from the status bits and an enable mask.

A control finite-state machine sequences each message. Its states are S_HELD (soft reset asserted), S_UNCFG (released, no control word yet), S_GAP (the one idle cycle after the control write), S_FEED (message words accepted), S_FLUSH (waiting for the core to finish) and S_DONE (digest waiting in the queue). The transitions are:

- held-to-unconfigured: the soft reset is released.
- any-to-held: the soft reset is written to 1.
- unconfigured-to-gap and done-to-gap: a control word is written.
- gap-to-feed: the message length is non-zero.
- gap-to-flush: the message length is zero.
- feed-to-flush: the final word is taken.
- flush-to-done: the core reports done.

Top module: `hash_regfront`

## Requirements
- R1: After `rst_n` is released, all of the following read as zero: the soft reset, both length words, the control word, the status word and the enable register. `irq` is low.
- R2: The soft reset register is at 0x00. Writing 1 to bit 0 holds the engine in S_HELD and empties the result queue. While the engine is held, data writes are discarded and set status bit 3, and a control write starts nothing. Writing 0 releases the engine to S_UNCFG.
- R3: The message length is a 64-bit count of bits. The high word is at 0x04 and the low word is at 0x08. Both read back as written.
- R4: The control word is at 0x0C. Bits [1:0] select the algorithm, which sets how many words the digest has: 0 gives 4 words, 1 gives 5, 2 gives 7 and 3 gives 8. A control write is taken only in S_HELD, S_UNCFG or S_DONE. A control write in S_UNCFG or S_DONE starts a message.
- R5: Control bits [9:8] set the lane order. Output bytes 3..0 are taken from input bytes 3,2,1,0 for code 0, 0,1,2,3 for code 1, 2,3,1,0 for code 2 and 1,0,3,2 for code 3.
- R6: A message takes ceil(bits/32) words. In the final word, only the upper K bytes are kept after reordering and the rest are zeroed. K is 4 when bits mod 32 is 0; otherwise K is ceil((bits mod 32)/8).
- R7: A data write in the cycle right after the control-write cycle is discarded and sets status bit 3. Data writes are accepted from the second cycle after the control write onward.
- R8: A data write in S_UNCFG, S_DONE or S_FLUSH is discarded and sets status bit 3.
- R9: The core stub's digest is defined from A, the XOR of all accepted words after reordering and trimming. Digest word i is A + i. Successive reads of 0x1C return word N-1 first and then count down to word 0.
- R10: A read of 0x1C while the queue is empty returns 0, sets status bit 2 and leaves the queue empty.
- R11: The status word is at 0x10. Bit 0 is high while the queue is not empty. Bit 1 is set when the digest is loaded. Bit 8 is high in S_GAP, S_FEED and S_FLUSH. Writing a mask to 0x18 clears the sticky bits 1 to 3 that the mask selects. Bits 0 and 8 are not affected by the clear.
- R12: The enable register is at 0x14, in bits [3:0]. `irq` is the OR, over bits 0 to 3, of status AND enable.
- R13: Fixed identification words are read at 0x40, 0x50, 0x60 and 0x70. Writes to these addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of 0x1C pops the queue |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the same cycle as the read strobe |
| dat_wr | input | 1 | Message word write strobe |
| dat_wdata | input | 32 | Message word |
| irq | output | 1 | Interrupt request |

## Verification
The main path is tried with a table of messages, and each entry varies something different.
- Algorithm: covering all four algorithm codes tells the digest lengths apart.
- Lane order: covering all four lane codes tells the byte permutations apart.
- Message length: the lengths are 0, 8, 13, 32, 72, 100 and 256 bits, which separate the no-trim, one-byte and two-byte final-word cases from a zero-word message.

Directed tests then place a data word exactly one cycle after the control write, write data while held, unconfigured or already done, and read past the end of the queue. They also clear the status bits one at a time and switch the interrupt enable, so that each sticky flag and the interrupt combination are observed on their own.

// File: rtl/hash_fe_pkg.sv
package hash_fe_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 2 * WORD_W;
    localparam int AW     = 8;

    localparam logic [AW-1:0] A_SRST = 8'h00;
    localparam logic [AW-1:0] A_LENH = 8'h04;
    localparam logic [AW-1:0] A_LENL = 8'h08;
    localparam logic [AW-1:0] A_CTL  = 8'h0C;
    localparam logic [AW-1:0] A_STAT = 8'h10;
    localparam logic [AW-1:0] A_IEN  = 8'h14;
    localparam logic [AW-1:0] A_ICLR = 8'h18;
    localparam logic [AW-1:0] A_RESQ = 8'h1C;
    localparam logic [AW-1:0] A_ID0  = 8'h40;
    localparam logic [AW-1:0] A_ID1  = 8'h50;
    localparam logic [AW-1:0] A_ID2  = 8'h60;
    localparam logic [AW-1:0] A_ID3  = 8'h70;

    typedef enum logic [2:0] {
        S_HELD, S_UNCFG, S_GAP, S_FEED, S_FLUSH, S_DONE
    } fe_state_t;

    function automatic logic [3:0] digest_words(input logic [1:0] alg);
        case (alg)
            2'd0:    return 4'd4;
            2'd1:    return 4'd5;
            2'd2:    return 4'd7;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/hash_lane_order.sv
module hash_lane_order
    import hash_fe_pkg::*;
(
    input  logic [1:0]        order_sel,
    input  logic [WORD_W-1:0] din,
    input  logic              trim_en,
    input  logic [2:0]        keep_bytes,
    output logic [WORD_W-1:0] dout
);
    localparam int LANES = WORD_W / 8;

    logic [WORD_W-1:0] ordered;

    always_comb begin
        unique case (order_sel)
            2'd0: ordered = din;
            2'd1: ordered = {din[7:0], din[15:8], din[23:16], din[31:24]};
            2'd2: ordered = {din[23:16], din[31:24], din[15:8], din[7:0]};
            2'd3: ordered = {din[15:8], din[7:0], din[31:24], din[23:16]};
        endcase
    end

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        localparam logic [31:0] RANK = 32'(LANES - 1 - gi);
        logic keep;
        assign keep = !trim_en || ({29'd0, keep_bytes} > RANK);
        assign dout[gi*8 +: 8] = keep ? ordered[gi*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/hash_core_stub.sv
module hash_core_stub
    import hash_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  need,
    input  logic              din_valid,
    input  logic [WORD_W-1:0] din,
    output logic              is_last,
    output logic [WORD_W-1:0] acc,
    output logic              done
);
    logic [LEN_W-1:0] cnt;

    assign is_last = (cnt + LEN_W'(1)) == need;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            acc  <= '0;
            done <= 1'b0;
        end else if (start) begin
            cnt  <= '0;
            acc  <= '0;
            done <= (need == '0);
        end else begin
            done <= din_valid && is_last;
            if (din_valid) begin
                cnt <= cnt + LEN_W'(1);
                acc <= acc ^ din;
            end
        end
    end

endmodule

// File: rtl/hash_result_q.sv
module hash_result_q #(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          load,
    input  logic [CW-1:0] load_n,
    input  logic [DW-1:0] base,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    logic [DEPTH*DW-1:0] flat;
    logic [CW-1:0]       top_idx;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic [DW-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    slot_q <= '0;
            else if (load) slot_q <= base + DW'(gi);
        end
        assign flat[gi*DW +: DW] = slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    count <= '0;
        else if (flush)                count <= '0;
        else if (load)                 count <= load_n;
        else if (pop && count != '0)   count <= count - CW'(1);
    end

    assign top_idx = count - CW'(1);
    assign head    = (count == '0) ? '0 : flat[IW'(top_idx)*DW +: DW];

    assert_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0 && !load && !flush) |=> count == '0);

    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

// File: rtl/hash_regfront.sv
module hash_regfront
    import hash_fe_pkg::*;
#(
    parameter int          QDEPTH = 8,
    parameter logic [31:0] ID_W0  = 32'h0001_0004,
    parameter logic [31:0] ID_W1  = 32'h00A5_1C3E,
    parameter logic [31:0] ID_W2  = 32'h0000_000F,
    parameter logic [31:0] ID_W3  = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [AW-1:0]     reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              dat_wr,
    input  logic [WORD_W-1:0] dat_wdata,
    output logic              irq
);
    localparam int CW = $clog2(QDEPTH + 1);

    fe_state_t state, state_nxt;

    logic              hold_q;
    logic [WORD_W-1:0] len_hi, len_lo;
    logic [1:0]        alg_q, ord_q;
    logic [3:0]        ien_q;
    logic              st_new, st_rderr, st_wrerr;

    logic [LEN_W-1:0]  bit_len, need_w;
    logic [2:0]        keep_bytes;
    logic              start_core, take, load_q, busy, ctl_open;
    logic              last_w, core_done, bad_data, rd_q, rd_empty;
    logic [WORD_W-1:0] lane_out, acc, q_head, stat_word;
    logic [CW-1:0]     q_count;

    assign bit_len    = {len_hi, len_lo};
    assign need_w     = (bit_len >> 5) + LEN_W'(|bit_len[4:0]);
    assign keep_bytes = (bit_len[4:0] == 5'd0) ? 3'd4
                      : 3'(({1'b0, bit_len[4:0]} + 6'd7) >> 3);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_UNCFG;
        else        state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (hold_q) begin
            state_nxt = S_HELD;
        end else begin
            unique case (state)
                S_HELD:  state_nxt = S_UNCFG;
                S_UNCFG,
                S_DONE:  if (reg_wr && reg_addr == A_CTL) state_nxt = S_GAP;
                S_GAP:   state_nxt = (need_w == '0) ? S_FLUSH : S_FEED;
                S_FEED:  if (take && last_w) state_nxt = S_FLUSH;
                S_FLUSH: if (core_done) state_nxt = S_DONE;
            endcase
        end
    end

    // state-decoded outputs
    always_comb begin
        start_core = 1'b0;
        take       = 1'b0;
        load_q     = 1'b0;
        busy       = 1'b0;
        ctl_open   = 1'b0;
        unique case (state)
            S_HELD:  ctl_open = 1'b1;
            S_UNCFG: ctl_open = 1'b1;
            S_DONE:  ctl_open = 1'b1;
            S_GAP:   begin start_core = 1'b1; busy = 1'b1; end
            S_FEED:  begin take = dat_wr && !hold_q; busy = 1'b1; end
            S_FLUSH: begin load_q = core_done && !hold_q; busy = 1'b1; end
        endcase
    end

    assign bad_data = dat_wr && !take;
    assign rd_q     = reg_rd && reg_addr == A_RESQ;
    assign rd_empty = rd_q && q_count == '0;

    hash_lane_order u_lane (
        .order_sel (ord_q),
        .din       (dat_wdata),
        .trim_en   (last_w),
        .keep_bytes(keep_bytes),
        .dout      (lane_out)
    );

    hash_core_stub u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_core),
        .need     (need_w),
        .din_valid(take),
        .din      (lane_out),
        .is_last  (last_w),
        .acc      (acc),
        .done     (core_done)
    );

    hash_result_q #(.DEPTH(QDEPTH), .DW(WORD_W)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (hold_q),
        .load  (load_q),
        .load_n(CW'(digest_words(alg_q))),
        .base  (acc),
        .pop   (rd_q),
        .head  (q_head),
        .count (q_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q   <= 1'b0;
            len_hi   <= '0;
            len_lo   <= '0;
            alg_q    <= '0;
            ord_q    <= '0;
            ien_q    <= '0;
            st_new   <= 1'b0;
            st_rderr <= 1'b0;
            st_wrerr <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    A_SRST: hold_q <= reg_wdata[0];
                    A_LENH: len_hi <= reg_wdata;
                    A_LENL: len_lo <= reg_wdata;
                    A_CTL:  if (ctl_open) begin
                                alg_q <= reg_wdata[1:0];
                                ord_q <= reg_wdata[9:8];
                            end
                    A_IEN:  ien_q <= reg_wdata[3:0];
                    default: ;
                endcase
            end
            st_new   <= load_q   | (st_new   & ~(reg_wr && reg_addr == A_ICLR && reg_wdata[1]));
            st_rderr <= rd_empty | (st_rderr & ~(reg_wr && reg_addr == A_ICLR && reg_wdata[2]));
            st_wrerr <= bad_data | (st_wrerr & ~(reg_wr && reg_addr == A_ICLR && reg_wdata[3]));
        end
    end

    assign stat_word = {23'd0, busy, 4'd0, st_wrerr, st_rderr, st_new, q_count != '0};
    assign irq       = |(stat_word[3:0] & ien_q);

    always_comb begin
        case (reg_addr)
            A_SRST:  reg_rdata = {31'd0, hold_q};
            A_LENH:  reg_rdata = len_hi;
            A_LENL:  reg_rdata = len_lo;
            A_CTL:   reg_rdata = {22'd0, ord_q, 6'd0, alg_q};
            A_STAT:  reg_rdata = stat_word;
            A_IEN:   reg_rdata = {28'd0, ien_q};
            A_RESQ:  reg_rdata = q_head;
            A_ID0:   reg_rdata = ID_W0;
            A_ID1:   reg_rdata = ID_W1;
            A_ID2:   reg_rdata = ID_W2;
            A_ID3:   reg_rdata = ID_W3;
            default: reg_rdata = '0;
        endcase
    end

    assert_hold_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |=> (state == S_HELD && q_count == '0));

    assert_gap_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP && dat_wr) |=> st_wrerr);

    assert_unconfig_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_UNCFG && dat_wr) |=> st_wrerr);

    assert_load_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FLUSH && core_done && !hold_q) |=> q_count == CW'(digest_words(alg_q)));

    assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && q_count == '0) |=> st_rderr);

endmodule

// File: tb/test_hash_regfront.sv
module test_hash_regfront;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, dat_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, dat_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    hash_regfront i_hash_regfront (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .irq(irq)
    );

    // {alg[1:0], order[1:0], bits[15:0], seed[31:0]}
    localparam int NV = 7;
    localparam logic [51:0] VEC [NV] = '{
        {2'd0, 2'd0, 16'd0,   32'h1111_2222},
        {2'd1, 2'd1, 16'd8,   32'hA1B2_C3D4},
        {2'd2, 2'd2, 16'd32,  32'h0BAD_F00D},
        {2'd3, 2'd3, 16'd100, 32'h1357_9BDF},
        {2'd1, 2'd0, 16'd13,  32'hCAFE_BABE},
        {2'd3, 2'd1, 16'd256, 32'h0246_8ACE},
        {2'd0, 2'd2, 16'd72,  32'h5A5A_A5A5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all bus tasks are entered at a falling edge and leave at a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic dwr(input logic [31:0] d);
        dat_wr = 1'b1; dat_wdata = d;
        @(negedge clk);
        dat_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] gen_word(input logic [31:0] seed, input int j);
        return seed ^ (32'(j) * 32'h9E37_79B9);
    endfunction

    function automatic logic [31:0] reorder(input logic [31:0] w, input logic [1:0] o);
        case (o)
            2'd0:    return w;
            2'd1:    return {w[7:0], w[15:8], w[23:16], w[31:24]};
            2'd2:    return {w[23:16], w[31:24], w[15:8], w[7:0]};
            default: return {w[15:8], w[7:0], w[31:24], w[23:16]};
        endcase
    endfunction

    function automatic logic [31:0] model_acc(input logic [1:0] o, input int bits, input logic [31:0] seed);
        int need = (bits + 31) / 32;
        logic [31:0] a = '0;
        for (int j = 0; j < need; j++) begin
            logic [31:0] r = reorder(gen_word(seed, j), o);
            if (j == need - 1) begin
                int kb = (bits % 32 == 0) ? 4 : ((bits % 32) + 7) / 8;
                for (int b = 0; b < 4; b++)
                    if ((3 - b) >= kb) r[b*8 +: 8] = 8'h00;
            end
            a ^= r;
        end
        return a;
    endfunction

    function automatic int nwords(input logic [1:0] alg);
        case (alg)
            2'd0: return 4;
            2'd1: return 5;
            2'd2: return 7;
            default: return 8;
        endcase
    endfunction

    task automatic run_msg(input logic [1:0] alg, input logic [1:0] o, input int bits,
                           input logic [31:0] seed);
        logic [31:0] d, a;
        int need = (bits + 31) / 32;
        int n = nwords(alg);
        wr(8'h00, 32'd1);
        wr(8'h00, 32'd0);
        wr(8'h14, 32'h2);
        wr(8'h04, 32'd0);
        wr(8'h08, 32'(bits));
        wr(8'h0C, {22'd0, o, 6'd0, alg});
        idle(1);
        for (int j = 0; j < need; j++) dwr(gen_word(seed, j));
        idle(2);
        rd(8'h10, d);
        check("R11 status after digest", d, 32'h0000_0003);
        check("R12 irq on new results", 32'(irq), 32'd1);
        a = model_acc(o, bits, seed);
        for (int i = n - 1; i >= 0; i--) begin
            rd(8'h1C, d);
            check("R9 R5 R6 R4 digest word", d, a + 32'(i));
        end
        rd(8'h1C, d);
        check("R10 empty read data", d, 32'd0);
        rd(8'h10, d);
        check("R10 R11 status after drain", d, 32'h0000_0006);
        wr(8'h18, 32'h0000_000E);
        rd(8'h10, d);
        check("R11 status after clear", d, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, d); check("R1 soft reset", d, 32'd0);
        rd(8'h04, d); check("R1 len hi", d, 32'd0);
        rd(8'h08, d); check("R1 len lo", d, 32'd0);
        rd(8'h0C, d); check("R1 control", d, 32'd0);
        rd(8'h10, d); check("R1 status", d, 32'd0);
        rd(8'h14, d); check("R1 enable", d, 32'd0);
        check("R1 irq", 32'(irq), 32'd0);

        // R13 identification words, writes ignored
        rd(8'h40, d); check("R13 id0", d, 32'h0001_0004);
        rd(8'h50, d); check("R13 id1", d, 32'h00A5_1C3E);
        wr(8'h60, 32'hFFFF_FFFF);
        rd(8'h60, d); check("R13 id2 after write", d, 32'h0000_000F);
        rd(8'h70, d); check("R13 id3", d, 32'h0000_0100);

        // R3 length readback
        wr(8'h04, 32'hDEAD_0001);
        wr(8'h08, 32'h8000_0040);
        rd(8'h04, d); check("R3 len hi", d, 32'hDEAD_0001);
        rd(8'h08, d); check("R3 len lo", d, 32'h8000_0040);

        // R8 data before any control write
        dwr(32'h1234_5678);
        rd(8'h10, d); check("R8 unconfigured write flag", d, 32'h0000_0008);
        wr(8'h14, 32'h8);
        check("R12 irq from bit 3", 32'(irq), 32'd1);
        wr(8'h14, 32'h0);
        check("R12 irq masked", 32'(irq), 32'd0);
        wr(8'h18, 32'h8);

        // table of messages
        for (int v = 0; v < NV; v++)
            run_msg(VEC[v][51:50], VEC[v][49:48], int'(VEC[v][47:32]), VEC[v][31:0]);

        // R7 data in the cycle right after the control write
        wr(8'h00, 32'd1);
        wr(8'h00, 32'd0);
        wr(8'h14, 32'h0);
        wr(8'h04, 32'd0);
        wr(8'h08, 32'd32);
        wr(8'h0C, 32'd0);
        dwr(32'hAAAA_0000);
        dwr(32'h0000_5555);
        idle(2);
        rd(8'h10, d); check("R7 gap reject flag", d, 32'h0000_000B);
        check("R12 irq with enable cleared", 32'(irq), 32'd0);
        rd(8'h1C, d); check("R7 second word taken", d, 32'h0000_5558);

        // R8 data after digest complete
        wr(8'h18, 32'hE);
        dwr(32'h0101_0101);
        rd(8'h10, d); check("R8 done-state write flag", d, 32'h0000_0009);

        // R11 selective clear
        rd(8'h1C, d); rd(8'h1C, d); rd(8'h1C, d);
        rd(8'h1C, d);
        rd(8'h10, d); check("R10 R11 bits 2 and 3 set", d, 32'h0000_000C);
        wr(8'h18, 32'h4);
        rd(8'h10, d); check("R11 clear bit 2 only", d, 32'h0000_0008);
        wr(8'h18, 32'h8);

        // R2 hold: queue flushed, control ignored, data rejected
        wr(8'h0C, 32'd3);
        idle(1);
        dwr(32'hFFFF_FFFF);
        wr(8'h00, 32'd1);
        idle(1);
        rd(8'h10, d); check("R2 hold empties queue", d & 32'h1, 32'd0);
        wr(8'h18, 32'hE);
        wr(8'h0C, 32'd1);
        dwr(32'h7777_7777);
        rd(8'h10, d); check("R2 held data rejected", d, 32'h0000_0008);
        rd(8'h00, d); check("R2 hold readback", d, 32'd1);
        wr(8'h00, 32'd0);
        idle(1);
        dwr(32'h7777_7777);
        rd(8'h10, d); check("R2 released but unconfigured", d, 32'h0000_0008);
        rd(8'h0C, d); check("R4 control while held taken", d, 32'd1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule